// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block is the combinational integer datapath of a load/store RISC pipeline's execute stage. Each evaluation takes two register operands (`rs_val`, `rt_val`), a 16-bit instruction immediate, a 5-bit constant shift count and a 4-bit operation code. It returns a 32-bit result, a signed-overflow flag and a writeback enable.

Two steering inputs cover the instruction variants without extra operation codes. `imm_sel` replaces the second register operand with the extended immediate. `shift_var` takes the shift count from the low bits of `rs_val` instead of the constant field. How the immediate is widened depends on the operation class: bitwise operations pad it with zeros, while arithmetic and compare operations replicate its top bit.

The trapping add and subtract detect two's-complement overflow. When it occurs they drop the writeback enable, so the destination register keeps its old value, and they raise the flag for the exception logic. The result port still carries the wrapped value.

Top module: `int_exec_unit`

## Requirements
- R1: For op 0 (add) and op 2 (sub), signed overflow sets `ovf`=1 and `wb_en`=0 while `result` carries the wrapped sum or difference. Add overflows when both operands share a sign and the result sign differs. Sub overflows when the operand signs differ and the result sign differs from `rs_val`. Without overflow, `ovf`=0 and `wb_en`=1.
- R2: Op 1 (unsigned add) and op 3 (unsigned sub) return the modulo-2^32 result, always with `ovf`=0 and `wb_en`=1. This includes their immediate forms.
- R3: Ops 4 (and), 5 (or), 6 (xor) and 7 (nor) combine `rs_val` with the second operand bitwise. Nor returns ~(rs | second).
- R4: When `imm_sel`=1, ops 4..7 use the immediate zero-extended to 32 bits. Ops 0..3, 8 and 9 use it sign-extended from bit 15. When `imm_sel`=0, the second operand is `rt_val`.
- R5: Op 10 (upper load) returns `imm` in bits 31..16 and zeros in bits 15..0.
- R6: Ops 11..13 shift `rt_val`. The count is `shamt` when `shift_var`=0, and `rs_val`[4:0] when `shift_var`=1.
- R7: Op 11 shifts left, filling with zeros. Op 12 shifts right, filling with zeros. Op 13 shifts right, filling vacated bits with `rt_val`[31].
- R8: Op 8 returns 1 if `rs_val` is less than the second operand as two's complement, and 0 otherwise. Op 9 makes the same comparison unsigned. All other result bits are zero.
- R9: Op codes 14 and 15 are unused. They give `result`=0, `ovf`=0 and `wb_en`=1. Only ops 0 and 2 can ever raise `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_val | input | 32 | First register operand; its low 5 bits are the variable shift count |
| rt_val | input | 32 | Second register operand; also the shift source |
| imm | input | 16 | Instruction immediate |
| shamt | input | 5 | Constant shift count |
| op | input | 4 | Operation code (see R1..R9) |
| imm_sel | input | 1 | 1: second operand is the extended immediate |
| shift_var | input | 1 | 1: shift count taken from `rs_val`[4:0] |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow on a trapping add or sub |
| wb_en | output | 1 | 0 when writeback must be suppressed |

## Verification
Some steering inputs meet an operation in the same evaluation. The immediate extension rule meets a trapping add when `imm_sel` is high and a sign-extended immediate pushes a near-limit `rs_val` past the signed range. The sweep pairs operand values near the signed limits with immediates that have bit 15 both set and clear, so both the extension and the overflow decision are judged together. The bench computes its expected overflow from 64-bit signed sums. The variable shift count and an arithmetic right shift also coincide, because `rs_val` both supplies the count and is swept over values whose low five bits differ.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_LUI  = 4'd10,
    OP_SLL  = 4'd11,
    OP_SRL  = 4'd12,
    OP_SRA  = 4'd13
  } exec_op_e;

  // Bitwise class takes a zero-padded immediate.
  function automatic logic is_bitwise(input logic [3:0] code);
    return (code >= 4'd4) && (code <= 4'd7);
  endfunction

  function automatic logic is_trapping(input logic [3:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

endpackage

// File: rtl/int_exec_operand.sv
module int_exec_operand #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] rt_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [3:0]       op,
  input  logic             imm_sel,
  output logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] imm_zext,
  output logic [WIDTH-1:0] imm_sext
);
  import int_exec_pkg::*;

  localparam int PAD = WIDTH - IMM_W;

  assign imm_zext = {{PAD{1'b0}}, imm};
  assign imm_sext = {{PAD{imm[IMM_W-1]}}, imm};

  always_comb begin
    if (!imm_sel)             opnd_b = rt_val;
    else if (is_bitwise(op))  opnd_b = imm_zext;
    else                      opnd_b = imm_sext;
  end
endmodule

// File: rtl/int_exec_addsub.sv
module int_exec_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             sgn_ovf
);
  localparam int MSB = WIDTH - 1;

  function automatic logic add_overflow(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  function automatic logic sub_overflow(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

  logic [WIDTH-1:0] b_eff;

  assign b_eff = subtract ? ~b : b;
  assign sum   = a + b_eff + {{(WIDTH-1){1'b0}}, subtract};

  assign sgn_ovf = subtract ? sub_overflow(a[MSB], b[MSB], sum[MSB])
                            : add_overflow(a[MSB], b[MSB], sum[MSB]);
endmodule

// File: rtl/int_exec_shifter.sv
module int_exec_shifter #(
  parameter int WIDTH = 32,
  parameter int SH_W  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src,
  input  logic [SH_W-1:0]  amount,
  input  logic             left,
  input  logic             arith,
  output logic [WIDTH-1:0] shifted
);
  logic             fill;
  logic [WIDTH-1:0] stage [SH_W+1];

  assign fill     = arith & src[WIDTH-1];
  assign stage[0] = src;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [WIDTH-1:0] moved;
    assign moved = left ? {stage[k][WIDTH-1-STEP:0], {STEP{1'b0}}}
                        : {{STEP{fill}}, stage[k][WIDTH-1:STEP]};
    assign stage[k+1] = amount[k] ? moved : stage[k];
  end

  assign shifted = stage[SH_W];
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] rs_val,
  input  logic [WIDTH-1:0] rt_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [SH_W-1:0]  shamt,
  input  logic [3:0]       op,
  input  logic             imm_sel,
  input  logic             shift_var,
  output logic [WIDTH-1:0] result,
  output logic             ovf,
  output logic             wb_en
);
  import int_exec_pkg::*;

  localparam int LO_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] imm_zext;
  logic [WIDTH-1:0] imm_sext;
  logic [WIDTH-1:0] arith_sum;
  logic             arith_ovf;
  logic             is_sub;
  logic [SH_W-1:0]  shift_amt;
  logic [WIDTH-1:0] shift_out;
  logic             lt_signed;
  logic             lt_unsigned;
  logic             trap_hit;

  int_exec_operand #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_operand (
    .rt_val   (rt_val),
    .imm      (imm),
    .op       (op),
    .imm_sel  (imm_sel),
    .opnd_b   (opnd_b),
    .imm_zext (imm_zext),
    .imm_sext (imm_sext)
  );

  assign is_sub = (op == OP_SUB) || (op == OP_SUBU);

  int_exec_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a        (rs_val),
    .b        (opnd_b),
    .subtract (is_sub),
    .sum      (arith_sum),
    .sgn_ovf  (arith_ovf)
  );

  assign shift_amt = shift_var ? rs_val[SH_W-1:0] : shamt;

  int_exec_shifter #(.WIDTH(WIDTH), .SH_W(SH_W)) u_shift (
    .src     (rt_val),
    .amount  (shift_amt),
    .left    (op == OP_SLL),
    .arith   (op == OP_SRA),
    .shifted (shift_out)
  );

  assign lt_signed   = $signed(rs_val) < $signed(opnd_b);
  assign lt_unsigned = rs_val < opnd_b;

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU,
      OP_SUB, OP_SUBU: result = arith_sum;
      OP_AND:          result = rs_val & opnd_b;
      OP_OR:           result = rs_val | opnd_b;
      OP_XOR:          result = rs_val ^ opnd_b;
      OP_NOR:          result = ~(rs_val | opnd_b);
      OP_SLT:          result = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU:         result = {{(WIDTH-1){1'b0}}, lt_unsigned};
      OP_LUI:          result = {imm, {LO_W{1'b0}}};
      OP_SLL, OP_SRL,
      OP_SRA:          result = shift_out;
      default:         result = '0;
    endcase
  end

  assign trap_hit = is_trapping(op) & arith_ovf;
  assign ovf      = trap_hit;
  assign wb_en    = ~trap_hit;
endmodule

// File: rtl/int_exec_checker.sv
module int_exec_checker #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input logic [3:0]       op,
  input logic [WIDTH-1:0] result,
  input logic             ovf,
  input logic             wb_en,
  input logic             arith_ovf
);
  always_comb begin
    if (!$isunknown({op, result, ovf, wb_en, arith_ovf})) begin
      a_r1_wb_follows_trap: assert (wb_en == !ovf)
        else $error("R1 writeback enable disagrees with trap");
      a_r2_no_overflow: assert (!((op == 4'd1 || op == 4'd3) && ovf))
        else $error("R2 unsigned arithmetic raised overflow");
      a_r5_upper_low_zero: assert (!(op == 4'd10 && result[WIDTH-IMM_W-1:0] != '0))
        else $error("R5 low half not zero");
      a_r8_compare_boolean: assert (!((op == 4'd8 || op == 4'd9) && result[WIDTH-1:1] != '0))
        else $error("R8 compare result not boolean");
      a_r9_unused_quiet: assert (!(op >= 4'd14 && (result != '0 || ovf)))
        else $error("R9 unused code not quiet");
      a_r9_trap_source: assert (!ovf || ((op == 4'd0 || op == 4'd2) && arith_ovf))
        else $error("R9 overflow from non-trapping op");
    end
  end
endmodule

bind int_exec_unit int_exec_checker #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_checker (
  .op        (op),
  .result    (result),
  .ovf       (ovf),
  .wb_en     (wb_en),
  .arith_ovf (arith_ovf)
);

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic [31:0] rs_val, rt_val;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic [3:0]  op;
  logic        imm_sel, shift_var;
  logic [31:0] result;
  logic        ovf, wb_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  int_exec_unit dut_i (
    .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .shamt(shamt), .op(op),
    .imm_sel(imm_sel), .shift_var(shift_var),
    .result(result), .ovf(ovf), .wb_en(wb_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] vals [8];
  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
    vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
    vals[6] = 32'hFFFF_8001; vals[7] = 32'h0000_7FF3;
  end

  function automatic string tag_of(input int code, input bit isel, input bit svar);
    if (isel && (code <= 9) && (code != 10)) return "R4";
    if (svar && code >= 11 && code <= 13) return "R6";
    case (code)
      0, 2:        return "R1";
      1, 3:        return "R2";
      4, 5, 6, 7:  return "R3";
      8, 9:        return "R8";
      10:          return "R5";
      11, 12, 13:  return "R7";
      default:     return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got_r, input logic [31:0] exp_r,
                       input logic got_o, input logic exp_o, input logic got_w, input logic exp_w);
    checks++;
    if (got_r !== exp_r || got_o !== exp_o || got_w !== exp_w) begin
      errors++;
      $display("FAIL %s op=%0d rs=%h rt=%h imm=%h: result=%h ovf=%b wb=%b expected result=%h ovf=%b wb=%b",
               tag, op, rs_val, rt_val, imm, got_r, got_o, got_w, exp_r, exp_o, exp_w);
    end
  endtask

  task automatic run_vec(input int code, input logic [31:0] a, input logic [31:0] r,
                         input logic [15:0] iv, input logic [4:0] sh, input bit isel, input bit svar);
    logic [31:0] b, er;
    logic        eo;
    longint      wide;
    int          amt;
    @(negedge clk);
    op = code[3:0]; rs_val = a; rt_val = r; imm = iv; shamt = sh;
    imm_sel = isel; shift_var = svar;
    // Second operand: R4 extension rule.
    if (!isel) b = r;
    else if (code >= 4 && code <= 7) b = {16'h0000, iv};
    else b = {{16{iv[15]}}, iv};
    amt = svar ? int'(a[4:0]) : int'(sh);
    eo = 1'b0; er = '0;
    case (code)
      0: begin wide = longint'($signed(a)) + longint'($signed(b)); er = a + b;
               eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      1: er = a + b;
      2: begin wide = longint'($signed(a)) - longint'($signed(b)); er = a - b;
               eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      3: er = a - b;
      4: er = a & b;
      5: er = a | b;
      6: er = a ^ b;
      7: er = ~a & ~b;
      8: er = (longint'($signed(a)) < longint'($signed(b))) ? 32'd1 : 32'd0;
      9: er = ({32'h0, a} < {32'h0, b}) ? 32'd1 : 32'd0;
      10: er = {iv, 16'h0000};
      11: er = r << amt;
      12: er = r >> amt;
      13: er = 32'($signed(r) >>> amt);
      default: er = '0;
    endcase
    #1;
    check(tag_of(code, isel, svar), result, er, ovf, eo, wb_en, !eo);
  endtask

  initial begin
    op = 4'd15; rs_val = '0; rt_val = '0; imm = '0; shamt = '0; imm_sel = 0; shift_var = 0;
    @(negedge clk); #1;
    check("R9", result, 32'h0, ovf, 1'b0, wb_en, 1'b1);
    for (int code = 0; code < 16; code++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int m = 0; m < 4; m++)
            run_vec(code, vals[i], vals[j], vals[j][31:16] ^ vals[(i+j)%8][15:0],
                    5'((i * 5 + j * 3) % 32), m[0], m[1]);
    // R1 directed: sign-extended immediate drives overflow.
    run_vec(0, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0, 1'b1, 1'b0);
    run_vec(0, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, 1'b1, 1'b0);
    run_vec(2, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0, 1'b0, 1'b0);
    // R7 directed: full 31-bit arithmetic shift.
    run_vec(13, 32'h0, 32'h8000_0000, 16'h0, 5'd31, 1'b0, 1'b0);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below %0d", cycles, WATCHDOG);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule